// File: doc/BRIEF.md
# Cascadable Loadable Up/Down Counter

The block is a binary counter built from 4-bit slices, with two slices by default for an 8-bit value. Each slice counts up or down. A slice can be cleared without a clock edge, or loaded in parallel from a data word. One active-low master enable freezes every action of a slice: counting, loading and clearing.

Every slice has an active-low terminal flag that goes low while its value is 1111. This flag holds no matter which direction is selected. Slices are chained through this flag. A slice steps only on edges where every slice below it shows 1111, so the upper nibble moves once for each pass of the lower nibble through 1111.

The flag can also be wired back into a slice's load input to give a restricted count range. One example wraps from 1111 to a preset value. Another decodes 1100 and returns to 0000.

Top module: `ctr_chain`

## Requirements
- R1: While `clr` is 1 and `en_n` is 0, the whole count becomes 0 at once, without waiting for a clock edge.
- R2: While `en_n` is 1, the count holds on every edge, even if `clr` is 1 or `ld_n` is 0.
- R3: On an edge with `en_n` 0 and `ld_n` 0, the count takes the value of `d`. The load wins over counting in either direction.
- R4: On an edge with `en_n` 0, `ld_n` 1 and `up` 1, the lowest slice (bits 3:0) increments modulo 16.
- R5: On an edge with `en_n` 0, `ld_n` 1 and `up` 0, the lowest slice decrements modulo 16.
- R6: A slice's flag `co_n` is 0 exactly while that slice holds 1111, whatever the value of `up`.
- R7: With `en_n` 0 and `ld_n` 1, the upper slice (bits 7:4) steps one place in the `up` direction on an edge where the lower slice holds 1111. On every other such edge it holds. When counting down, this makes the upper slice step as the lower slice leaves 1111.
- R8: The top flag `co_n` is 0 exactly while all bits of `q` are 1.
- R9: A slice whose `co_n` drives its own `ld_n`, with `d` = 0110 and counting up, runs 0110 through 1111 and then returns to 0110.
- R10: A slice whose `ld_n` is driven low by a decode of 1100, with `d` = 0000 and counting up, runs 0000 through 1100 and then returns to 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| clr | input | 1 | Asynchronous clear, active high, gated by `en_n` |
| en_n | input | 1 | Master enable, active low |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| ld_n | input | 1 | Parallel load, active low |
| d | input | 8 | Load data |
| q | output | 8 | Count value |
| co_n | output | 1 | Terminal flag, low while q is all ones |

## Verification
The clocked properties assume that `clr`, once raised, stays high across at least one rising edge. They also assume it changes only away from the edge. This keeps every edge-to-edge comparison either free of a clear or disabled by it. The bench drives all inputs on the falling edge. It raises `clr` mid-cycle only to check the immediate clear, and then holds it through the following edge. A clear attempted while `en_n` is 1 is not an exception to this, because that clear has no effect on the count.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
    localparam int SLICE_W = 4;
    typedef logic [SLICE_W-1:0] nib_t;
    typedef struct packed {
        nib_t cnt;
    } slice_st_t;
endpackage

// File: rtl/ctr_step.sv
module ctr_step
    import ctr_pkg::*;
(
    input  nib_t cur,
    input  logic up,
    input  logic ld_n,
    input  logic step_n,
    input  nib_t d,
    output nib_t nxt
);
    localparam nib_t ONE = nib_t'(1);

    always_comb begin
        nxt = cur;
        if (!ld_n) begin
            nxt = d;
        end else if (!step_n) begin
            nxt = up ? (cur + ONE) : (cur - ONE);
        end
    end
endmodule

// File: rtl/ctr_slice.sv
module ctr_slice
    import ctr_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic en_n,
    input  logic step_n,
    input  logic up,
    input  logic ld_n,
    input  nib_t d,
    output nib_t q,
    output logic co_n
);
    slice_st_t st_d, st_q;
    nib_t      nxt;
    logic      clr_hit;

    assign clr_hit = clr & ~en_n;

    ctr_step u_step (
        .cur    (st_q.cnt),
        .up     (up),
        .ld_n   (ld_n),
        .step_n (step_n),
        .d      (d),
        .nxt    (nxt)
    );

    always_comb begin
        st_d = st_q;
        if (!en_n) begin
            st_d.cnt = nxt;
        end
    end

    always_ff @(posedge clk or posedge clr_hit) begin
        if (clr_hit) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q    = st_q.cnt;
    assign co_n = ~&st_q.cnt;
endmodule

// File: rtl/ctr_chain.sv
module ctr_chain
    import ctr_pkg::*;
#(
    parameter int NSLICE = 2,
    localparam int TW = NSLICE * SLICE_W
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          en_n,
    input  logic          up,
    input  logic          ld_n,
    input  logic [TW-1:0] d,
    output logic [TW-1:0] q,
    output logic          co_n
);
    logic [NSLICE:0]   step_n;
    logic [NSLICE-1:0] sco_n;

    assign step_n[0] = 1'b0;

    for (genvar i = 0; i < NSLICE; i++) begin : g_slice
        ctr_slice u_slice (
            .clk    (clk),
            .clr    (clr),
            .en_n   (en_n),
            .step_n (step_n[i]),
            .up     (up),
            .ld_n   (ld_n),
            .d      (d[i*SLICE_W +: SLICE_W]),
            .q      (q[i*SLICE_W +: SLICE_W]),
            .co_n   (sco_n[i])
        );
        assign step_n[i+1] = step_n[i] | sco_n[i];
    end

    assign co_n = step_n[NSLICE];
endmodule

// File: rtl/ctr_chain_chk.sv
module ctr_chain_chk
    import ctr_pkg::*;
#(
    parameter int NSLICE = 2,
    localparam int TW = NSLICE * SLICE_W
) (
    input logic          clk,
    input logic          clr,
    input logic          en_n,
    input logic          up,
    input logic          ld_n,
    input logic [TW-1:0] d,
    input logic [TW-1:0] q,
    input logic          co_n
);
    localparam nib_t ONE  = nib_t'(1);
    localparam nib_t FULL = '1;

    always @(negedge clk) begin
        if (clr && !en_n) begin
            AST_CLEAR_NOW: assert (q == '0); // R1
        end
    end

    AST_FROZEN: assert property (@(posedge clk) disable iff (clr)
        en_n |=> $stable(q)); // R2

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (clr)
        (!en_n && !ld_n) |=> (q == $past(d))); // R3

    AST_LOW_INC: assert property (@(posedge clk) disable iff (clr)
        (!en_n && ld_n && up) |=> (q[SLICE_W-1:0] == $past(q[SLICE_W-1:0]) + ONE)); // R4

    AST_LOW_DEC: assert property (@(posedge clk) disable iff (clr)
        (!en_n && ld_n && !up) |=> (q[SLICE_W-1:0] == $past(q[SLICE_W-1:0]) - ONE)); // R5

    AST_UPPER_WAITS: assert property (@(posedge clk) disable iff (clr)
        (!en_n && ld_n && q[SLICE_W-1:0] != FULL)
        |=> (q[2*SLICE_W-1:SLICE_W] == $past(q[2*SLICE_W-1:SLICE_W]))); // R7

    AST_TOP_FLAG: assert property (@(posedge clk) disable iff (clr)
        co_n == (q != '1)); // R8
endmodule

bind ctr_chain ctr_chain_chk #(.NSLICE(NSLICE)) u_chk (
    .clk  (clk),
    .clr  (clr),
    .en_n (en_n),
    .up   (up),
    .ld_n (ld_n),
    .d    (d),
    .q    (q),
    .co_n (co_n)
);

// File: tb/sim_ctr_chain.sv
module sim_ctr_chain;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       clr = 1'b1;
    logic       en_n = 1'b0;
    logic       up = 1'b1;
    logic       ld_n = 1'b1;
    logic [7:0] d = 8'h00;
    logic [7:0] q;
    logic       co_n;

    logic [3:0] r1_q, r2_q;
    logic       r1_co, r2_co, r2_ld;

    int checks = 0;
    int errors = 0;
    int mlo = 0, mhi = 0, m1 = 0, m2 = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    ctr_chain u0 (.clk(clk), .clr(clr), .en_n(en_n), .up(up), .ld_n(ld_n),
                  .d(d), .q(q), .co_n(co_n));

    // restricted range: flag reloads 0110 (R9)
    ctr_slice u1 (.clk(clk), .clr(clr), .en_n(1'b0), .step_n(1'b0), .up(1'b1),
                  .ld_n(r1_co), .d(4'b0110), .q(r1_q), .co_n(r1_co));

    // restricted range: decode of 1100 reloads 0000 (R10)
    assign r2_ld = ~(r2_q == 4'b1100);
    ctr_slice u2 (.clk(clk), .clr(clr), .en_n(1'b0), .step_n(1'b0), .up(1'b1),
                  .ld_n(r2_ld), .d(4'b0000), .q(r2_q), .co_n(r2_co));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, int'(q), mhi * 16 + mlo);
        chk("R8", int'(co_n), (mhi == 15 && mlo == 15) ? 0 : 1);
        chk("R9", int'(r1_q), m1);
        chk("R6", int'(r1_co), (m1 == 15) ? 0 : 1);
        chk("R10", int'(r2_q), m2);
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        if (clr && !en_n) begin
            mlo = 0; mhi = 0;
        end else if (!en_n) begin
            if (!ld_n) begin
                mlo = int'(d[3:0]); mhi = int'(d[7:4]);
            end else begin
                if (mlo == 15) mhi = up ? (mhi + 1) % 16 : (mhi + 15) % 16;
                mlo = up ? (mlo + 1) % 16 : (mlo + 15) % 16;
            end
        end
        if (clr) begin
            m1 = 0; m2 = 0;
        end else begin
            m1 = (m1 == 15) ? 6 : m1 + 1;
            m2 = (m2 == 12) ? 0 : m2 + 1;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        // reset state (R1)
        tick("R1");
        tick("R1");
        clr = 1'b0;
        // count up through two lower wraps (R4, R7)
        for (int i = 0; i < 40; i++) tick("R4");
        // load with up set: load wins (R3)
        d = 8'hFE; ld_n = 1'b0;
        tick("R3");
        ld_n = 1'b1;
        for (int i = 0; i < 3; i++) tick("R7");
        // count down across lower boundary (R5, R7)
        d = 8'h03; ld_n = 1'b0; up = 1'b0;
        tick("R3");
        ld_n = 1'b1;
        for (int i = 0; i < 24; i++) tick("R5");
        // disabled: clear and load ignored (R2)
        en_n = 1'b1; ld_n = 1'b0; d = 8'h55; clr = 1'b1;
        for (int i = 0; i < 3; i++) tick("R2");
        clr = 1'b0; up = 1'b1;
        for (int i = 0; i < 3; i++) tick("R2");
        // resume and reach all ones (R8)
        en_n = 1'b0; d = 8'hFD;
        tick("R3");
        ld_n = 1'b1;
        for (int i = 0; i < 4; i++) tick("R8");
        // mid-cycle clear without edge (R1)
        #(CLK_P/4);
        clr = 1'b1;
        #1;
        mlo = 0; mhi = 0; m1 = 0; m2 = 0;
        chk("R1", int'(q), 0);
        chk("R1", int'(r1_q), 0);
        tick("R1");
        clr = 1'b0;
        // run ranges through their wraps (R9, R10)
        for (int i = 0; i < 40; i++) tick("R9");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule